// File: doc/BRIEF.md
# GPIO Port Register File

This block is a memory-mapped general-purpose I/O port with up to five groups of 32 pins. Software reaches it through a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. For each pin the block keeps a direction bit and an output latch. It drives an output-enable vector and an output-data vector toward the pads, and it samples the pad levels back into its own clock domain so that software can read them.

Each group has five registers. The direction register uses the inverted sense: 1 means input. The output latch can be written in full. It can also be changed one bit at a time through a set register and a clear register, so two agents that share a group never need a read-modify-write sequence. The input register returns the pad level after a two-flop synchronizer. It does this even for pins that are driving, so software can observe its own outputs from the pad side. Edge detection and interrupt logic belong to a companion block, and their offsets read as zero here.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1, every output latch bit is 0, and `pad_oe` and `pad_out` are all zeros.
- R2: A direction bit of 1 makes its pin an input (`pad_oe` bit 0). A bit of 0 makes it an output (`pad_oe` bit 1). A write takes effect on `pad_oe` after the clock edge that accepts it, and reading the direction register returns the stored bits.
- R3: A write to the output-data register replaces the whole latch, and `pad_out` follows it after the accepting edge. Without a write, `pad_oe` and `pad_out` hold their values.
- R4: A write to the set register sets every latch bit whose write-data bit is 1 and leaves the rest unchanged.
- R5: A write to the clear register clears every latch bit whose write-data bit is 1 and leaves the rest unchanged.
- R6: Reading the output-data, set or clear register returns the current output latch.
- R7: The input register returns the pad level through a two-flop synchronizer. A pad change made before clock edge k is first readable after edge k+1, and it still reads as the old level between edges k and k+1. This also holds for pins configured as outputs.
- R8: Group g (0 to 4) starts at byte address 0x10 + 0x28*g. Within a group the offsets are direction 0x00, output data 0x04, set 0x08, clear 0x0C and input 0x10.
- R9: Reads of any other address return zero. This covers misaligned addresses, offset 0x08 below the first group, offsets 0x14 to 0x24 inside a group, and anything past the last group.
- R10: Writes to any address not listed in R8 change no register and no pad output.
- R11: A write to one group leaves the registers and pad vectors of every other group unchanged.
- R12: A read in the same cycle as a write to the same register returns the value held before the write. The new value is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 160 | Pad levels, asynchronous to `clk` |
| pad_oe | output | 160 | Output enable per pin, 1 drives the pad |
| pad_out | output | 160 | Output level per pin |

## Verification
A register read and a register write can fall in the same cycle. This matters most when both target the same latch: the combinational read path must show the stored value, not the value being written. The bench provokes this by holding a write to a group's output register and sampling the read data in that cycle, before the edge, then again one cycle later. It expects the old value first and the new value second. A second overlap pairs an output write with a pad-side readback through the synchronizer. Here the bench checks that the input register keeps the old level across exactly one edge and shows the new level after the second edge.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int MAX_GROUPS = 5;
    localparam int GRP_IDX_W  = $clog2(MAX_GROUPS);
    localparam int GRP_BASE   = 32'h10;
    localparam int GRP_STRIDE = 32'h28;

    // word offsets inside one group
    localparam int OFS_DIR = 32'h00;
    localparam int OFS_OUT = 32'h04;
    localparam int OFS_SET = 32'h08;
    localparam int OFS_CLR = 32'h0C;
    localparam int OFS_IN  = 32'h10;

    typedef enum logic [2:0] {
        RK_DIR,
        RK_OUT,
        RK_SET,
        RK_CLR,
        RK_IN,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic                 hit;
        logic [GRP_IDX_W-1:0] grp;
        reg_kind_e            kind;
    } reg_sel_t;

    // byte address of a register in a group
    function automatic logic [ADDR_W-1:0] reg_addr(input int grp, input int ofs);
        return ADDR_W'(GRP_BASE + grp * GRP_STRIDE + ofs);
    endfunction

    // decode a bus address into group and register kind
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned ngrp);
        reg_sel_t    s;
        logic [31:0] ax;
        logic [31:0] rel;
        logic [31:0] g;
        logic [31:0] off;
        s.hit  = 1'b0;
        s.grp  = '0;
        s.kind = RK_NONE;
        ax     = 32'(a);
        if (ax >= 32'(GRP_BASE)) begin
            rel = ax - 32'(GRP_BASE);
            g   = rel / 32'(GRP_STRIDE);
            off = rel % 32'(GRP_STRIDE);
            if (g < 32'(ngrp)) begin
                case (off)
                    32'(OFS_DIR): s.kind = RK_DIR;
                    32'(OFS_OUT): s.kind = RK_OUT;
                    32'(OFS_SET): s.kind = RK_SET;
                    32'(OFS_CLR): s.kind = RK_CLR;
                    32'(OFS_IN):  s.kind = RK_IN;
                    default:      s.kind = RK_NONE;
                endcase
                s.grp = g[GRP_IDX_W-1:0];
            end
        end
        s.hit = (s.kind != RK_NONE);
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_d;
            stage2 <= stage1;
        end
    end

    assign sync_q = stage2;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_kind_e        wr_kind,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pad_lvl,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] lvl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                RK_DIR:  dir_q <= wr_data;
                RK_OUT:  lat_q <= wr_data;
                RK_SET:  lat_q <= lat_q | wr_data;
                RK_CLR:  lat_q <= lat_q & ~wr_data;
                default: ;
            endcase
        end
    end

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_d (pad_lvl),
        .sync_q  (lvl_q)
    );
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_GROUPS = MAX_GROUPS,
    localparam int NPINS     = NUM_GROUPS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
);
    reg_sel_t          sel;
    logic [DATA_W-1:0] grp_dir [NUM_GROUPS];
    logic [DATA_W-1:0] grp_lat [NUM_GROUPS];
    logic [DATA_W-1:0] grp_lvl [NUM_GROUPS];

    assign sel = decode_addr(bus_addr, NUM_GROUPS);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic bank_we;
        assign bank_we = bus_we && sel.hit && (sel.grp == GRP_IDX_W'(g));

        gpio_bank #(.WIDTH(DATA_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bank_we),
            .wr_kind (sel.kind),
            .wr_data (bus_wdata),
            .pad_lvl (pad_in[g*DATA_W +: DATA_W]),
            .dir_q   (grp_dir[g]),
            .lat_q   (grp_lat[g]),
            .lvl_q   (grp_lvl[g])
        );

        // direction 1 = input, so the enable is the inverse
        assign pad_oe[g*DATA_W +: DATA_W]  = ~grp_dir[g];
        assign pad_out[g*DATA_W +: DATA_W] = grp_lat[g];
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel.hit && sel.grp == GRP_IDX_W'(g)) begin
                case (sel.kind)
                    RK_DIR:                 bus_rdata = grp_dir[g];
                    RK_OUT, RK_SET, RK_CLR: bus_rdata = grp_lat[g];
                    RK_IN:                  bus_rdata = grp_lvl[g];
                    default:                bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_GROUPS = MAX_GROUPS,
    localparam int NPINS     = NUM_GROUPS * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out
);
    localparam logic [ADDR_W-1:0] A_DIR0 = reg_addr(0, OFS_DIR);
    localparam logic [ADDR_W-1:0] A_SET0 = reg_addr(0, OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR0 = reg_addr(0, OFS_CLR);

    logic unused_in;
    assign unused_in = ^pad_in;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0)); // R1

    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_DIR0) |-> (bus_rdata == ~pad_oe[DATA_W-1:0])); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !bus_we) |=> ($stable(pad_oe) && $stable(pad_out))); // R3

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (!rst && bus_we && bus_addr == A_SET0) |=>
        (pad_out[DATA_W-1:0] == ($past(pad_out[DATA_W-1:0]) | $past(bus_wdata)))); // R4

    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (!rst && bus_we && bus_addr == A_CLR0) |=>
        (pad_out[DATA_W-1:0] == ($past(pad_out[DATA_W-1:0]) & ~$past(bus_wdata)))); // R5

    AST_MISALIGNED_WR: assert property (@(posedge clk) disable iff (rst)
        (!rst && bus_we && bus_addr[1:0] != 2'b00) |=>
        ($stable(pad_oe) && $stable(pad_out))); // R10
endmodule

bind gpio_port gpio_port_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int NG    = 5;
    localparam int NPINS = NG * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       bus_addr = '0;
    logic             bus_we = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_oe;
    logic [NPINS-1:0] pad_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    logic [31:0] m_dir [NG];
    logic [31:0] m_out [NG];

    always #5 clk = ~clk;

    gpio_port #(.NUM_GROUPS(NG)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [7:0] ra(input int g, input int ofs);
        return 8'(32'h10 + g * 32'h28 + ofs);
    endfunction

    task automatic chk(input string req, input logic [NPINS-1:0] act,
                       input logic [NPINS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        logic [NPINS-1:0] eoe;
        logic [NPINS-1:0] eout;
        for (int g = 0; g < NG; g++) begin
            eoe[g*32 +: 32]  = ~m_dir[g];
            eout[g*32 +: 32] = m_out[g];
        end
        chk({req, " pad_oe"}, pad_oe, eoe);
        chk({req, " pad_out"}, pad_out, eout);
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        for (int g = 0; g < NG; g++) begin
            rd(ra(g, 0), v);
            chk({req, " dir"}, NPINS'(v), NPINS'(m_dir[g]));
            rd(ra(g, 4), v);
            chk({req, " out"}, NPINS'(v), NPINS'(m_out[g]));
        end
    endtask

    task automatic t_reset;
        for (int g = 0; g < NG; g++) begin
            m_dir[g] = '1;
            m_out[g] = '0;
        end
        check_pads("R1 reset");
        check_regs("R1 reset");
    endtask

    task automatic t_direction;
        logic [31:0] v;
        wr(ra(1, 0), 32'hFFFF_0000);
        m_dir[1] = 32'hFFFF_0000;
        check_pads("R2 dir write");
        rd(ra(1, 0), v);
        chk("R2 dir readback", NPINS'(v), NPINS'(32'hFFFF_0000));
        wr(ra(4, 0), 32'h0000_0001);
        m_dir[4] = 32'h0000_0001;
        rd(ra(4, 0), v);
        chk("R8 last group dir at 0xB0", NPINS'(v), NPINS'(32'h0000_0001));
        check_pads("R11 dir groups independent");
    endtask

    task automatic t_output;
        wr(ra(2, 4), 32'hA5A5_5A5A);
        m_out[2] = 32'hA5A5_5A5A;
        check_pads("R3 out write");
        check_regs("R11 others untouched");
    endtask

    task automatic t_set_clear;
        logic [31:0] v;
        wr(ra(0, 4), 32'h0000_00F0);
        wr(ra(0, 8), 32'h0F00_000F);
        m_out[0] = 32'h0F00_00FF;
        check_pads("R4 set");
        rd(ra(0, 8), v);
        chk("R6 read via set", NPINS'(v), NPINS'(32'h0F00_00FF));
        rd(ra(0, 12), v);
        chk("R6 read via clear", NPINS'(v), NPINS'(32'h0F00_00FF));
        wr(ra(0, 12), 32'h0000_00F3);
        m_out[0] = 32'h0F00_000C;
        check_pads("R5 clear");
        wr(ra(0, 8), 32'h0000_0000);
        check_pads("R4 set zero no effect");
        wr(ra(0, 12), 32'h0000_0000);
        check_pads("R5 clear zero no effect");
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk);
        pad_in[3*32 +: 32] = 32'h1234_5678;
        @(negedge clk);
        rd(ra(3, 16), v);
        chk("R7 one edge still old", NPINS'(v), NPINS'(32'h0));
        @(negedge clk);
        rd(ra(3, 16), v);
        chk("R7 two edges new level", NPINS'(v), NPINS'(32'h1234_5678));
        wr(ra(0, 0), 32'h0000_0000);
        m_dir[0] = 32'h0;
        pad_in[31:0] = 32'hC0DE_0001;
        @(negedge clk);
        @(negedge clk);
        rd(ra(0, 16), v);
        chk("R7 output pin reads pad", NPINS'(v), NPINS'(32'hC0DE_0001));
        check_pads("R7 pads after input test");
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        logic [7:0]  holes [7];
        holes[0] = 8'h00; holes[1] = 8'h08; holes[2] = ra(0, 20);
        holes[3] = ra(1, 36); holes[4] = 8'h11; holes[5] = ra(4, 20);
        holes[6] = 8'hD8;
        for (int i = 0; i < 7; i++) begin
            rd(holes[i], v);
            chk($sformatf("R9 read hole %h", holes[i]), NPINS'(v), '0);
        end
        for (int i = 0; i < 7; i++) wr(holes[i], 32'hFFFF_FFFF);
        wr(8'h15, 32'h0);
        wr(8'h1A, 32'hFFFF_FFFF);
        check_pads("R10 unmapped writes");
        check_regs("R10 unmapped writes");
    endtask

    task automatic t_independent;
        wr(ra(4, 4), 32'hDEAD_BEEF);
        m_out[4] = 32'hDEAD_BEEF;
        wr(ra(4, 12), 32'h0000_000F);
        m_out[4] = 32'hDEAD_BEE0;
        check_pads("R11 group4 only");
        check_regs("R11 group4 only");
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        @(negedge clk);
        bus_addr = ra(2, 4); bus_we = 1'b1; bus_wdata = 32'h1357_9BDF;
        #1;
        chk("R12 read during write old", NPINS'(bus_rdata), NPINS'(m_out[2]));
        @(negedge clk);
        bus_we = 1'b0;
        m_out[2] = 32'h1357_9BDF;
        rd(ra(2, 4), v);
        chk("R12 read next cycle new", NPINS'(v), NPINS'(32'h1357_9BDF));
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direction();
        t_output();
        t_set_clear();
        t_input();
        t_unmapped();
        t_independent();
        t_same_cycle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule